// File: doc/BRIEF.md
# Accumulator CPU with Micro-Step Sequencer

This block is a small 8-bit accumulator processor. Each 8-bit instruction carries a 4-bit opcode in its upper half and a 4-bit memory address in its lower half. Code and data share one 16-byte memory, which the core reads through a combinational port: the core drives an address and receives the byte in the same cycle. The core holds a 4-bit program counter, an instruction register, an accumulator, an operand latch, an output register, and zero and carry flags produced by an add/subtract ALU.

A four-state sequencer (T0 to T3) runs every instruction. T0 presents the program counter to memory. T1 captures the instruction and advances the counter. T2 presents the operand address and performs the memory-side action. T3 writes the ALU result back for arithmetic instructions. Execution is controlled by two debounced pulse inputs. One toggles free running. The other executes exactly one instruction while the core is stopped. A halt instruction freezes the core until reset.

Top module: `acc_cpu`

## Requirements
- R1: While reset (synchronous, active high) is asserted, the core clears the accumulator, OUT, operand latch, instruction register, program counter and both flags. After reset, running and halted are low and the memory address output is 0.
- R2: Opcodes sit in instruction bits 7:4 and the operand address in bits 3:0. The encodings are: 0x0 loads A from memory[operand]; 0x1 adds memory[operand] to A; 0x2 subtracts memory[operand] from A; 0xE copies A to OUT; 0xF halts. Every other opcode is a no-op that only advances the program counter.
- R3: Add sets carry to bit 8 of the 9-bit sum. Subtract sets carry to the borrow, which is high when the memory operand exceeds A. Both set zero when the 8-bit result is 0. No other instruction changes either flag.
- R4: Every instruction takes four clock cycles, T0 to T3 in order. The memory address output shows the operand field during T2 and the program counter otherwise. The program counter advances by one per instruction and wraps from 15 to 0.
- R5: A rising edge on the run-toggle input starts free execution when stopped and stops it when running. The running output is high while running. A stop lets the current instruction finish, so the core always comes to rest at an instruction boundary.
- R6: A rising edge on the step input while stopped and idle executes exactly one instruction. Holding the step input high counts as one edge.
- R7: A halt instruction raises the halted output and clears running. Until the next reset, run-toggle and step edges have no effect, and A and OUT do not change.
- R8: OUT changes only through the output instruction, and then takes the accumulator value.
- R9: The program that loads 0x64, adds 0x32 and 0x68 from memory, outputs and halts leaves 0xFE in OUT, with zero and carry both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_tgl | input | 1 | Debounced run/stop toggle, acts on rising edge |
| step_req | input | 1 | Debounced single-step request, acts on rising edge |
| mem_addr | output | 4 | Address to the program/data memory |
| mem_data | input | 8 | Combinational read data for mem_addr |
| out_value | output | 8 | OUT register |
| acc_value | output | 8 | Accumulator A |
| zero_flag | output | 1 | Zero flag |
| carry_flag | output | 1 | Carry / borrow flag |
| running | output | 1 | High while free-running |
| halted | output | 1 | High after a halt instruction until reset |

## Verification
Three kinds of internal fault reach the ports quickly. A wrong sequencer step or a mis-decoded opcode shows up within one instruction, four cycles, as a wrong accumulator, flag or program-counter value on the idle memory address. A stop that lands mid-instruction leaves the accumulator out of step with the program counter, and this is visible as soon as the core is at rest. A wrong run or halt state shows on running and halted one cycle after the triggering edge, and also as instructions that do or do not execute on the next step.

// File: rtl/acc_cpu_pkg.sv
`timescale 1ns/1ps
package acc_cpu_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_LDA = 4'h0,
        OP_ADD = 4'h1,
        OP_SUB = 4'h2,
        OP_OUT = 4'hE,
        OP_HLT = 4'hF
    } opcode_e;

    typedef enum logic [1:0] {
        T0 = 2'd0,
        T1 = 2'd1,
        T2 = 2'd2,
        T3 = 2'd3
    } tstep_e;

    typedef struct packed {
        logic ir_load;
        logic pc_inc;
        logic addr_opnd;
        logic a_from_mem;
        logic b_load;
        logic a_from_alu;
        logic alu_sub;
        logic out_load;
        logic halt_set;
    } ctrl_t;

    // Micro-step decode: control word for one step of one opcode
    function automatic ctrl_t decode(input tstep_e st, input logic [OPC_W-1:0] opc);
        ctrl_t c;
        c = '0;
        case (st)
            T1: begin
                c.ir_load = 1'b1;
                c.pc_inc  = 1'b1;
            end
            T2: begin
                c.addr_opnd = 1'b1;
                case (opc)
                    OP_LDA:         c.a_from_mem = 1'b1;
                    OP_ADD, OP_SUB: c.b_load     = 1'b1;
                    OP_OUT:         c.out_load   = 1'b1;
                    OP_HLT:         c.halt_set   = 1'b1;
                    default:        ;
                endcase
            end
            T3: begin
                if (opc == OP_ADD || opc == OP_SUB) begin
                    c.a_from_alu = 1'b1;
                    c.alu_sub    = (opc == OP_SUB);
                end
            end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/acc_cpu_alu.sv
`timescale 1ns/1ps
module acc_cpu_alu #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sub,
    output logic [DW-1:0] y,
    output logic          cout,
    output logic          zero
);
    logic [DW:0] wide;

    always_comb begin
        if (sub) wide = {1'b0, a} - {1'b0, b};
        else     wide = {1'b0, a} + {1'b0, b};
        y    = wide[DW-1:0];
        cout = wide[DW];
        zero = (wide[DW-1:0] == '0);
    end
endmodule

// File: rtl/acc_cpu_runctl.sv
`timescale 1ns/1ps
module acc_cpu_runctl (
    input  logic clk,
    input  logic rst,
    input  logic run_tgl,
    input  logic step_req,
    input  logic halt_set,
    input  logic at_t0,
    output logic running,
    output logic halted,
    output logic step_go
);
    logic run_d, step_d;
    logic run_rise, step_rise;

    assign run_rise  = run_tgl  & ~run_d;
    assign step_rise = step_req & ~step_d;
    assign step_go   = step_rise & ~running & ~halted & at_t0;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_d   <= 1'b0;
            step_d  <= 1'b0;
            running <= 1'b0;
            halted  <= 1'b0;
        end else begin
            run_d  <= run_tgl;
            step_d <= step_req;
            if (halt_set) begin
                halted  <= 1'b1;
                running <= 1'b0;
            end else if (run_rise && !halted) begin
                running <= ~running;
            end
        end
    end
endmodule

// File: rtl/acc_cpu_seq.sv
`timescale 1ns/1ps
module acc_cpu_seq
    import acc_cpu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    input  logic [OPC_W-1:0] opc,
    output tstep_e           st,
    output ctrl_t            ctrl
);
    always_ff @(posedge clk) begin
        if (rst)          st <= T0;
        else if (advance) st <= tstep_e'(st + 2'd1);
    end

    assign ctrl = decode(st, opc);
endmodule

// File: rtl/acc_cpu_dp.sv
`timescale 1ns/1ps
module acc_cpu_dp
    import acc_cpu_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic [DW-1:0]    mem_data,
    output logic [AW-1:0]    mem_addr,
    output logic [OPC_W-1:0] opc,
    output logic [DW-1:0]    acc_q,
    output logic [DW-1:0]    out_q,
    output logic             zf_q,
    output logic             cf_q
);
    logic [AW-1:0] pc_q;
    logic [DW-1:0] ir_q;
    logic [DW-1:0] b_q;
    logic [DW-1:0] alu_y;
    logic          alu_c, alu_z;

    acc_cpu_alu #(.DW(DW)) u_alu (
        .a    (acc_q),
        .b    (b_q),
        .sub  (ctrl.alu_sub),
        .y    (alu_y),
        .cout (alu_c),
        .zero (alu_z)
    );

    assign mem_addr = ctrl.addr_opnd ? ir_q[AW-1:0] : pc_q;
    assign opc      = ir_q[DW-1 -: OPC_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            ir_q  <= '0;
            acc_q <= '0;
            b_q   <= '0;
            out_q <= '0;
            zf_q  <= 1'b0;
            cf_q  <= 1'b0;
        end else begin
            if (ctrl.ir_load)    ir_q  <= mem_data;
            if (ctrl.pc_inc)     pc_q  <= pc_q + 1'b1;
            if (ctrl.a_from_mem) acc_q <= mem_data;
            if (ctrl.b_load)     b_q   <= mem_data;
            if (ctrl.a_from_alu) begin
                acc_q <= alu_y;
                zf_q  <= alu_z;
                cf_q  <= alu_c;
            end
            if (ctrl.out_load)   out_q <= acc_q;
        end
    end
endmodule

// File: rtl/acc_cpu.sv
`timescale 1ns/1ps
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_tgl,
    input  logic          step_req,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_data,
    output logic [DW-1:0] out_value,
    output logic [DW-1:0] acc_value,
    output logic          zero_flag,
    output logic          carry_flag,
    output logic          running,
    output logic          halted
);
    tstep_e           seq_st;
    ctrl_t            ctrl;
    logic [OPC_W-1:0] opc;
    logic             step_go;
    logic             advance;

    assign advance = (seq_st != T0) || running || step_go;

    acc_cpu_runctl u_runctl (
        .clk      (clk),
        .rst      (rst),
        .run_tgl  (run_tgl),
        .step_req (step_req),
        .halt_set (ctrl.halt_set),
        .at_t0    (seq_st == T0),
        .running  (running),
        .halted   (halted),
        .step_go  (step_go)
    );

    acc_cpu_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .advance (advance),
        .opc     (opc),
        .st      (seq_st),
        .ctrl    (ctrl)
    );

    acc_cpu_dp #(.DW(DW), .AW(AW)) u_dp (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl),
        .mem_data (mem_data),
        .mem_addr (mem_addr),
        .opc      (opc),
        .acc_q    (acc_value),
        .out_q    (out_value),
        .zf_q     (zero_flag),
        .cf_q     (carry_flag)
    );
endmodule

// File: rtl/acc_cpu_chk.sv
`timescale 1ns/1ps
module acc_cpu_chk
    import acc_cpu_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          running,
    input logic          halted,
    input logic [DW-1:0] acc_value,
    input logic [DW-1:0] out_value,
    input logic          zero_flag,
    input logic          carry_flag,
    input tstep_e        st
);
    logic rst_d = 1'b0;
    always_ff @(posedge clk) rst_d <= rst;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst_d |-> (acc_value == '0 && out_value == '0 && !running && !halted
                   && !zero_flag && !carry_flag && st == T0));

    // R4
    step_t1_chk: assert property (@(posedge clk) disable iff (rst)
        (st == T1) |=> (st == T2));

    // R4
    step_t2_chk: assert property (@(posedge clk) disable iff (rst)
        (st == T2) |=> (st == T3));

    // R4
    step_t3_chk: assert property (@(posedge clk) disable iff (rst)
        (st == T3) |=> (st == T0));

    // R3
    flag_timing_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(zero_flag) || !$stable(carry_flag)) |-> ($past(st) == T3));

    // R7
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R7
    halt_not_running_chk: assert property (@(posedge clk) disable iff (rst)
        halted |-> !running);

    // R7
    halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> ($stable(acc_value) && $stable(out_value)));

    // R8
    out_from_acc_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(out_value) |-> (out_value == $past(acc_value)));
endmodule

bind acc_cpu acc_cpu_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .running    (running),
    .halted     (halted),
    .acc_value  (acc_value),
    .out_value  (out_value),
    .zero_flag  (zero_flag),
    .carry_flag (carry_flag),
    .st         (seq_st)
);

// File: tb/acc_cpu_bench.sv
`timescale 1ns/1ps
module acc_cpu_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       run_tgl, step_req;
    logic [3:0] mem_addr;
    logic [7:0] mem_data;
    logic [7:0] out_value, acc_value;
    logic       zero_flag, carry_flag, running, halted;

    logic [7:0] rom [16];
    assign mem_data = rom[mem_addr];

    always #2.5 clk = ~clk;

    acc_cpu u_acc_cpu (
        .clk(clk), .rst(rst), .run_tgl(run_tgl), .step_req(step_req),
        .mem_addr(mem_addr), .mem_data(mem_data), .out_value(out_value),
        .acc_value(acc_value), .zero_flag(zero_flag), .carry_flag(carry_flag),
        .running(running), .halted(halted)
    );

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    // reference model state
    logic [7:0] ma, mo;
    logic       mz, mc, mh;
    logic [3:0] mpc;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        ma = 8'h00; mo = 8'h00; mz = 1'b0; mc = 1'b0; mh = 1'b0; mpc = 4'h0;
    endtask

    // one instruction per R2/R3 encodings
    task automatic model_exec();
        logic [7:0] ins, opv;
        if (!mh) begin
            ins = rom[mpc];
            mpc = mpc + 4'd1;
            opv = rom[ins[3:0]];
            case (ins[7:4])
                4'h0: ma = opv;
                4'h1: begin {mc, ma} = {1'b0, ma} + {1'b0, opv}; mz = (ma == 8'h00); end
                4'h2: begin mc = (opv > ma); ma = ma - opv; mz = (ma == 8'h00); end
                4'hE: mo = ma;
                4'hF: mh = 1'b1;
                default: ;
            endcase
        end
    endtask

    task automatic compare_model(input string req);
        check(req, "acc",     acc_value,  ma);
        check(req, "out",     out_value,  mo);
        check(req, "zero",    zero_flag,  mz);
        check(req, "carry",   carry_flag, mc);
        check(req, "pc",      mem_addr,   mpc);
        check(req, "halted",  halted,     mh);
        check(req, "running", running,    1'b0);
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1; run_tgl = 1'b0; step_req = 1'b0;
        wait_cycles(3);
        rst = 1'b0;
        wait_cycles(1);
    endtask

    task automatic pulse_run();
        @(negedge clk) run_tgl = 1'b1;
        @(negedge clk) run_tgl = 1'b0;
    endtask

    task automatic pulse_step();
        @(negedge clk) step_req = 1'b1;
        @(negedge clk) step_req = 1'b0;
    endtask

    task automatic run_steps(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            pulse_step();
            wait_cycles(6);
            model_exec();
            compare_model(req);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] a_save;
        logic [3:0] p_save;
        void'($urandom(32'd2024));
        rst = 1'b1; run_tgl = 1'b0; step_req = 1'b0;
        for (int i = 0; i < 16; i++) rom[i] = 8'h00;
        apply_reset();

        // R1 reset state
        check("R1", "acc",      acc_value,  8'h00);
        check("R1", "out",      out_value,  8'h00);
        check("R1", "zero",     zero_flag,  1'b0);
        check("R1", "carry",    carry_flag, 1'b0);
        check("R1", "mem_addr", mem_addr,   4'h0);
        check("R1", "running",  running,    1'b0);
        check("R1", "halted",   halted,     1'b0);

        // R9 sample program, free running (R5)
        for (int i = 0; i < 16; i++) rom[i] = 8'h00;
        rom[0] = 8'h05; rom[1] = 8'h16; rom[2] = 8'h17; rom[3] = 8'hE0; rom[4] = 8'hF0;
        rom[5] = 8'h64; rom[6] = 8'h32; rom[7] = 8'h68;
        apply_reset();
        pulse_run();
        check("R5", "running", running, 1'b1);
        for (int i = 0; i < 300 && !halted; i++) @(negedge clk);
        wait_cycles(2);
        check("R9", "out",     out_value,  8'hFE);
        check("R9", "acc",     acc_value,  8'hFE);
        check("R9", "zero",    zero_flag,  1'b0);
        check("R9", "carry",   carry_flag, 1'b0);
        check("R7", "halted",  halted,     1'b1);
        check("R7", "running", running,    1'b0);
        check("R4", "pc",      mem_addr,   4'h5);

        // R7 edges ignored after halt
        pulse_run();
        wait_cycles(4);
        check("R7", "running after toggle", running, 1'b0);
        pulse_step();
        wait_cycles(6);
        check("R7", "pc after step", mem_addr,  4'h5);
        check("R7", "acc after step", acc_value, 8'hFE);
        apply_reset();
        check("R7", "halted cleared by reset", halted, 1'b0);

        // R2/R3 directed flag corners, stepped (R6)
        for (int i = 0; i < 16; i++) rom[i] = 8'h00;
        rom[0] = 8'h08; rom[1] = 8'h19; rom[2] = 8'h2A; rom[3] = 8'hE0;
        rom[4] = 8'h2C; rom[5] = 8'h3D; rom[6] = 8'hE0; rom[7] = 8'hF0;
        rom[8] = 8'hFF; rom[9] = 8'h01; rom[10] = 8'h05; rom[12] = 8'hFB;
        apply_reset();
        model_reset();
        run_steps(10, "R3");

        // R2 random programs, stepped and compared with the model
        for (int t = 0; t < 20; t++) begin
            for (int i = 0; i < 16; i++) begin
                logic [3:0] op;
                case ($urandom % 6)
                    0: op = 4'h0;
                    1: op = 4'h1;
                    2: op = 4'h2;
                    3: op = 4'hE;
                    4: op = 4'hF;
                    default: op = 4'($urandom);
                endcase
                rom[i] = {op, 4'($urandom)};
            end
            apply_reset();
            model_reset();
            run_steps(16, "R2");
        end

        // R6 held step input counts once
        for (int i = 0; i < 16; i++) rom[i] = 8'h10;
        apply_reset();
        @(negedge clk) step_req = 1'b1;
        wait_cycles(20);
        step_req = 1'b0;
        wait_cycles(4);
        check("R6", "pc after held step",  mem_addr,  4'h1);
        check("R6", "acc after held step", acc_value, 8'h10);

        // R5 stop lands on an instruction boundary; R4 pc wrap
        apply_reset();
        pulse_run();
        wait_cycles(97);
        check("R5", "running", running, 1'b1);
        pulse_run();
        wait_cycles(8);
        check("R5", "stopped", running, 1'b0);
        a_save = acc_value;
        p_save = mem_addr;
        check("R5", "acc vs pc at boundary", acc_value, {p_save, 4'h0});
        wait_cycles(30);
        check("R5", "pc held while stopped",  mem_addr,  p_save);
        check("R5", "acc held while stopped", acc_value, a_save);
        check("R8", "out untouched by add",   out_value, 8'h00);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule